// File: doc/BRIEF.md
# Bidirectional GPIO Port with Grouped Pull-ups

This block is one 8-bit general-purpose I/O port on a microcontroller's register bus. It holds an output latch and a per-pin direction register. Pull-up enables are set in groups of four adjacent pins. The block drives registered per-pin output value, output-enable and pull-up-enable signals toward the pad ring.

A display controller outside the block can take over any pin. It does so through a per-pin segment-enable mask and a matching segment data vector. A taken-over pin drives the segment data, and its direction, latch and pull-up settings have no effect.

Pad input is brought in through a two-flop synchroniser before software reads it. A build-time parameter selects a second variant, an output-only port. That variant has no direction register and no pull-up register. One global control bit turns on all of its drivers, and its pins are pulled up while that bit is clear.

The register map is fixed:

| Offset | Register |
|---|---|
| 0 | data |
| 1 | direction |
| 2 | pull-up groups |
| 3 | output control |

Read data is registered, so `rd_data` reflects the offset presented on the previous clock edge.

Top module: `gpio_port`

## Requirements
- R1: In the bidirectional variant, direction bit i = 1 makes pin i an output (`pin_oe[i]` = 1) and 0 makes it an input (`pin_oe[i]` = 0), unless the segment override holds pin i.
- R2: A read of offset 0 returns the output latch bit for every pin whose port driver is enabled.
- R3: A read of offset 0 returns the pad level for every pin whose port driver is disabled, taken through two synchroniser flops, so a pad change seen at clock edge k appears in read data captured at edge k+2 or later.
- R4: A write to offset 0 stores all eight latch bits, even for input pins. Input pins stay undriven, and a later switch to output drives the stored value.
- R5: Pull-up register bit g (offset 2) enables the pull-ups of pins 4g to 4g+3.
- R6: No pin has its pull-up enabled while it is driven (`pin_pu & pin_oe` is always 0).
- R7: A pin with its segment enable set has its pull-up disabled, whatever the pull-up register holds.
- R8: A pin with its segment enable set has `pin_oe` = 1 and drives `pin_out` = segment data, whatever its direction and latch bits are.
- R9: Bits 7..2 of offset 2 read as 0. In the bidirectional variant, offset 3 reads as 0.
- R10: Reset (synchronous, active high) clears the latch, the direction register, the pull-up register and `rd_data`, so every pin starts as an undriven input.
- R11: In the output-only variant:
  - bit 0 of offset 3 enables all eight drivers and resets to 0;
  - while that bit is 0, every pin not held by the segment override is pulled up;
  - offset 1 reads 0 and ignores writes;
  - offset 0 always reads the latch.
- R12: Pin outputs and read data are registered. A register write or a segment-input change at edge k shows on the pins at edge k+1. `rd_data` at edge k reflects the register state before that edge's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 2 | Register offset (0 data, 1 direction, 2 pull-up groups, 3 output control) |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the offset presented on the previous edge |
| pad_in | input | 8 | Asynchronous pad levels |
| seg_en | input | 8 | Per-pin segment takeover mask |
| seg_data | input | 8 | Segment drive values |
| pin_out | output | 8 | Registered pin drive value |
| pin_oe | output | 8 | Registered pin output enable |
| pin_pu | output | 8 | Registered pin pull-up enable |

## Verification
The assertions assume that `seg_en`, `seg_data`, the bus inputs and the reset are synchronous to `clk` and stable around its rising edge. Only `pad_in` is treated as asynchronous. The bench respects this by changing every input on the falling edge.

The bench keeps `pad_in` away from the read-data assertions: those assertions constrain only latch-backed bits and constant-zero bits. The two-flop delay of `pad_in` is checked against a behavioural model that replays the pad history.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    GP_DATA = 2'd0,
    GP_DIR  = 2'd1,
    GP_PULL = 2'd2,
    GP_OCTL = 2'd3
  } gp_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W        = 8,
  parameter int PU_GROUP = 4,
  parameter bit OUT_ONLY = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [1:0]             addr,
  input  logic [W-1:0]           wdata,
  input  logic [W-1:0]           pad_sync,
  output logic [W-1:0]           lat,
  output logic [W-1:0]           drv_en,
  output logic [W/PU_GROUP-1:0]  pu_grp,
  output logic [W-1:0]           rdata
);
  localparam int NGRP = W / PU_GROUP;

  gp_reg_e      sel;
  logic [W-1:0] lat_q;
  logic [W-1:0] rd_nxt;
  logic [W-1:0] dir_view;
  logic [W-1:0] pull_view;
  logic [W-1:0] octl_view;
  logic [W-1:0] data_view;

  assign sel = gp_reg_e'(addr);

  always_ff @(posedge clk) begin
    if (rst)                      lat_q <= '0;
    else if (wr && sel == GP_DATA) lat_q <= wdata;
  end
  assign lat = lat_q;

  generate
    if (OUT_ONLY) begin : g_outonly
      logic octl_q;
      always_ff @(posedge clk) begin
        if (rst)                      octl_q <= 1'b0;
        else if (wr && sel == GP_OCTL) octl_q <= wdata[0];
      end
      assign drv_en    = {W{octl_q}};
      assign pu_grp    = {NGRP{~octl_q}};
      assign dir_view  = '0;
      assign pull_view = '0;
      always_comb begin
        octl_view    = '0;
        octl_view[0] = octl_q;
      end
      assign data_view = lat_q;

      p_dir_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (sel == GP_DIR) |=> (rdata == '0));
    end else begin : g_bidir
      logic [W-1:0]    dir_q;
      logic [NGRP-1:0] pu_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dir_q <= '0;
          pu_q  <= '0;
        end else if (wr) begin
          if (sel == GP_DIR)  dir_q <= wdata;
          if (sel == GP_PULL) pu_q  <= wdata[NGRP-1:0];
        end
      end
      assign drv_en   = dir_q;
      assign pu_grp   = pu_q;
      assign dir_view = dir_q;
      always_comb begin
        pull_view            = '0;
        pull_view[NGRP-1:0]  = pu_q;
      end
      assign octl_view = '0;
      assign data_view = (lat_q & dir_q) | (pad_sync & ~dir_q);

      p_pull_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (sel == GP_PULL) |=> ((rdata >> NGRP) == '0));
    end
  endgenerate

  always_comb begin
    unique case (sel)
      GP_DATA: rd_nxt = data_view;
      GP_DIR:  rd_nxt = dir_view;
      GP_PULL: rd_nxt = pull_view;
      default: rd_nxt = octl_view;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end

  p_read_out_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == GP_DATA) |=> ((rdata & $past(drv_en)) == ($past(lat) & $past(drv_en))));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W        = 8,
  parameter int PU_GROUP = 4,
  parameter bit OUT_ONLY = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          lat,
  input  logic [W-1:0]          drv_en,
  input  logic [W/PU_GROUP-1:0] pu_grp,
  input  logic [W-1:0]          seg_en,
  input  logic [W-1:0]          seg_data,
  output logic [W-1:0]          pin_out,
  output logic [W-1:0]          pin_oe,
  output logic [W-1:0]          pin_pu
);
  localparam logic [W-1:0] PU_RST = OUT_ONLY ? {W{1'b1}} : '0;

  logic [W-1:0] pu_pin;
  logic [W-1:0] out_nxt, oe_nxt, pu_nxt;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign pu_pin[i]  = pu_grp[i / PU_GROUP];
      assign out_nxt[i] = seg_en[i] ? seg_data[i] : lat[i];
      assign oe_nxt[i]  = seg_en[i] | drv_en[i];
      assign pu_nxt[i]  = pu_pin[i] & ~drv_en[i] & ~seg_en[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
      pin_pu  <= PU_RST;
    end else begin
      pin_out <= out_nxt;
      pin_oe  <= oe_nxt;
      pin_pu  <= pu_nxt;
    end
  end

  p_oe_tracks_dir_r1: assert property (@(posedge clk) disable iff (rst)
    (seg_en == '0) |=> (pin_oe == $past(drv_en)));

  p_no_pull_on_drive_r6: assert property (@(posedge clk) disable iff (rst)
    ((pin_pu & pin_oe) == '0));

  p_seg_takeover_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_oe & $past(seg_en)) == $past(seg_en)) &&
              ((pin_out & $past(seg_en)) == ($past(seg_data) & $past(seg_en)))));

  p_seg_no_pull_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_pu & $past(seg_en)) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W        = 8,
  parameter int PU_GROUP = 4,
  parameter int SYNC_STG = 2,
  parameter bit OUT_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] seg_en,
  input  logic [W-1:0] seg_data,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu
);
  localparam int NGRP = W / PU_GROUP;

  logic [W-1:0]    pad_s;
  logic [W-1:0]    lat;
  logic [W-1:0]    drv_en;
  logic [NGRP-1:0] pu_grp;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_async(pad_in), .d_sync(pad_s)
  );

  gpio_port_regs #(.W(W), .PU_GROUP(PU_GROUP), .OUT_ONLY(OUT_ONLY)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pad_sync(pad_s), .lat(lat), .drv_en(drv_en), .pu_grp(pu_grp), .rdata(rd_data)
  );

  gpio_pad_drive #(.W(W), .PU_GROUP(PU_GROUP), .OUT_ONLY(OUT_ONLY)) u_drive (
    .clk(clk), .rst(rst), .lat(lat), .drv_en(drv_en), .pu_grp(pu_grp),
    .seg_en(seg_en), .seg_data(seg_data),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, pad = 8'h00, sen = 8'h00, sdat = 8'h00;
  logic [7:0] rd0, out0, oe0, pu0, rd1, out1, oe1, pu1;

  int    checks = 0, errors = 0;
  string cur_req = "R10";
  bit    done = 1'b0;
  bit    armed = 1'b0;

  always #5 clk = ~clk;

  gpio_port #(.OUT_ONLY(1'b0)) u0 (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .rd_data(rd0), .pad_in(pad), .seg_en(sen), .seg_data(sdat),
    .pin_out(out0), .pin_oe(oe0), .pin_pu(pu0));

  gpio_port #(.OUT_ONLY(1'b1)) u1 (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .rd_data(rd1), .pad_in(pad), .seg_en(sen), .seg_data(sdat),
    .pin_out(out1), .pin_oe(oe1), .pin_pu(pu1));

  // Behavioural reference: index 0 bidirectional, 1 output-only
  logic [7:0] m_lat [2];
  logic [7:0] m_dir [2];
  logic [1:0] m_pu  [2];
  logic       m_oc  [2];
  logic [7:0] pad_hist [$];
  logic [7:0] e_rd [2], e_out [2], e_oe [2], e_pu [2];

  function automatic logic [7:0] drive_of(int v);
    return (v == 1) ? {8{m_oc[1]}} : m_dir[0];
  endfunction

  always @(posedge clk) begin
    logic [7:0] s2;
    s2 = (pad_hist.size() == 2) ? pad_hist[0] : 8'h00;
    for (int v = 0; v < 2; v++) begin
      if (rst) begin
        e_rd[v] = 8'h00; e_out[v] = 8'h00; e_oe[v] = 8'h00;
        e_pu[v] = (v == 1) ? 8'hFF : 8'h00;
      end else begin
        logic [7:0] d, pg;
        d = drive_of(v);
        for (int i = 0; i < 8; i++)
          pg[i] = (v == 1) ? ~m_oc[1] : m_pu[v][i/4];
        e_out[v] = (sen & sdat) | (~sen & m_lat[v]);
        e_oe[v]  = sen | d;
        e_pu[v]  = pg & ~d & ~sen;
        case (addr)
          2'd0: e_rd[v] = (v == 1) ? m_lat[v] : ((m_lat[v] & d) | (s2 & ~d));
          2'd1: e_rd[v] = (v == 1) ? 8'h00 : m_dir[v];
          2'd2: e_rd[v] = (v == 1) ? 8'h00 : {6'd0, m_pu[v]};
          default: e_rd[v] = (v == 1) ? {7'd0, m_oc[v]} : 8'h00;
        endcase
      end
    end
    for (int v = 0; v < 2; v++) begin
      if (rst) begin
        m_lat[v] = 8'h00; m_dir[v] = 8'h00; m_pu[v] = 2'b00; m_oc[v] = 1'b0;
      end else if (wr) begin
        if (addr == 2'd0) m_lat[v] = wdata;
        if (addr == 2'd1 && v == 0) m_dir[v] = wdata;
        if (addr == 2'd2 && v == 0) m_pu[v] = wdata[1:0];
        if (addr == 2'd3 && v == 1) m_oc[v] = wdata[0];
      end
    end
    if (rst) pad_hist.delete();
    else begin
      pad_hist.push_back(pad);
      if (pad_hist.size() > 2) void'(pad_hist.pop_front());
    end
    armed = 1'b1;
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R12 timing)
  always @(negedge clk) begin
    if (armed && !done) begin
      chk(cur_req, "u0 rd_data", rd0, e_rd[0]);
      chk(cur_req, "u0 pin_out", out0, e_out[0]);
      chk(cur_req, "u0 pin_oe", oe0, e_oe[0]);
      chk(cur_req, "u0 pin_pu", pu0, e_pu[0]);
      chk(cur_req, "u1 rd_data", rd1, e_rd[1]);
      chk(cur_req, "u1 pin_out", out1, e_out[1]);
      chk(cur_req, "u1 pin_oe", oe1, e_oe[1]);
      chk(cur_req, "u1 pin_pu", pu1, e_pu[1]);
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] a);
    addr = a;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    idle(3);
    rst = 1'b0;
    idle(2);
    cur_req = "R10";
    chk("R10", "reset oe", oe0, 8'h00);
    chk("R10", "reset pu", pu0, 8'h00);
    chk("R11", "reset pu out-only", pu1, 8'hFF);
    rreg(2'd1); chk("R10", "reset dir read", rd0, 8'h00);

    cur_req = "R1";
    wreg(2'd1, 8'hA5); idle(1);
    chk("R1", "oe after dir write", oe0, 8'hA5);
    chk("R11", "out-only ignores dir", oe1, 8'h00);

    cur_req = "R2";
    pad = 8'hFF;
    wreg(2'd0, 8'h3C); idle(3);
    rreg(2'd0);
    chk("R2", "mixed data read", rd0, 8'h7E);
    chk("R11", "out-only data read", rd1, 8'h3C);

    cur_req = "R3";
    pad = 8'h00;
    rreg(2'd0); chk("R3", "pad not yet synced", rd0, 8'h7E);
    idle(2);
    rreg(2'd0); chk("R3", "pad synced", rd0, 8'h24);

    cur_req = "R4";
    wreg(2'd1, 8'h00); wreg(2'd0, 8'h99); idle(1);
    chk("R4", "input write undriven", oe0, 8'h00);
    wreg(2'd1, 8'hFF); idle(1);
    chk("R4", "latched value driven", out0, 8'h99);

    cur_req = "R5";
    wreg(2'd1, 8'h00); wreg(2'd2, 8'h01); idle(1);
    chk("R5", "group 0 pull", pu0, 8'h0F);
    wreg(2'd2, 8'h02); idle(1);
    chk("R5", "group 1 pull", pu0, 8'hF0);

    cur_req = "R6";
    wreg(2'd2, 8'h03); wreg(2'd1, 8'h0F); idle(1);
    chk("R6", "pull off on outputs", pu0, 8'hF0);

    cur_req = "R7";
    wreg(2'd1, 8'h00); sen = 8'h30; idle(1);
    chk("R7", "pull off on segment pins", pu0, 8'hCF);

    cur_req = "R8";
    sen = 8'hF0; sdat = 8'h5A;
    wreg(2'd1, 8'h0F); idle(1);
    chk("R8", "segment oe", oe0, 8'hFF);
    chk("R8", "segment data", out0, 8'h59);

    cur_req = "R9";
    sen = 8'h00;
    wreg(2'd2, 8'hFF);
    rreg(2'd2); chk("R9", "pull unused bits", rd0, 8'h03);
    rreg(2'd3); chk("R9", "octl in bidir", rd0, 8'h00);

    cur_req = "R11";
    wreg(2'd3, 8'h01); idle(1);
    chk("R11", "global enable oe", oe1, 8'hFF);
    chk("R11", "global enable pu", pu1, 8'h00);
    chk("R11", "global enable out", out1, 8'h99);
    rreg(2'd3); chk("R11", "octl read", rd1, 8'h01);
    wreg(2'd1, 8'h55); rreg(2'd1); chk("R11", "dir reads zero", rd1, 8'h00);
    wreg(2'd3, 8'hFE); idle(1);
    chk("R11", "global disable oe", oe1, 8'h00);
    chk("R11", "global disable pu", pu1, 8'hFF);

    cur_req = "R12";
    for (int k = 0; k < 600; k++) begin
      wr    = ($urandom_range(0, 2) == 0);
      addr  = 2'($urandom_range(0, 3));
      wdata = 8'($urandom);
      if ($urandom_range(0, 3) == 0) pad = 8'($urandom);
      if ($urandom_range(0, 4) == 0) sen = 8'($urandom);
      sdat  = 8'($urandom);
      @(negedge clk);
    end
    wr = 1'b0;
    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule